// File: doc/BRIEF.md
# Oscillator Frequency-Lock Controller

This block closes a frequency-locked loop around a tunable reference oscillator. An external counter compares the oscillator with a one-pulse-per-second timing reference over a 16-second window. It delivers one signed error value per window, marked by a one-cycle strobe. The controller screens each error against a magnitude limit and collects the accepted errors over an averaging cycle of programmable length. At the end of that cycle it moves a 14-bit tuning code for the oscillator's control-voltage converter. The next sample after every code change is discarded, so that the oscillator can settle before a new cycle is measured.

Two correction modes are available. The sum mode moves the code by a scaled copy of the summed error. The vote mode counts only the signs of the errors and moves the code by one step. A polarity input adapts the loop to oscillators whose frequency falls as the control voltage rises. A lock-state machine grades the trust in the output: unlocked, locked, holdover and off. It drives a two-colour status lamp and a signal that can gate the reference outputs while the loop is unlocked.

Top module: `fll_ctrl`

## Requirements
- R1: After reset the state is unlocked (code 0), the tuning code is DAC_INIT (8192), `dac_load` is low, only the red lamp is on, and `ref_inhibit` follows `inhibit_en`.
- R2: A sample whose error magnitude exceeds `cfg_err_lim` is rejected. It neither adds to the sum nor counts toward the averaging cycle.
- R3: When the `cfg_avg_n`-th accepted sample of a cycle arrives, `dac_load` pulses for exactly one cycle, one clock after that sample's strobe. The new code is on `dac_code` in the same cycle. The code changes at no other time.
- R4: In sum mode (`vote_mode`=0) the new code is the old code minus (sum of errors arithmetically shifted right by SUM_SHIFT, 2 by default) when `slope_neg`=0. It is the old code plus that amount when `slope_neg`=1.
- R5: The first valid sample after each code update is discarded, whatever its value. The next averaging cycle starts with the sample after it.
- R6: In vote mode the code steps by one toward correcting the majority sign of the cycle's errors, and the sizes of the errors play no part. A positive majority lowers the code when `slope_neg`=0 and raises it when `slope_neg`=1. On a tie the code stays the same, but `dac_load` still pulses.
- R7: The updated code is clamped to the range 0 to 16383.
- R8: In the unlocked state, after `cfg_lock_n` consecutive averaging cycles that contain no rejected sample, the state becomes locked (code 1). A rejected sample restarts this count.
- R9: A rejected sample in the locked state enters holdover (code 2). An accepted sample in holdover returns to locked. In holdover, the (`cfg_hold_max`+1)-th rejected sample after the entering one moves the state to unlocked.
- R10: While `fll_en` is low the state is off (code 3), samples are ignored and the code is held. When `fll_en` returns, the state is unlocked and a fresh averaging cycle starts, with no settling discard.
- R11: The lamps show green alone when locked, red and green together in holdover, and red alone when unlocked or off.
- R12: `ref_inhibit` is high exactly when `inhibit_en` is high and the state is unlocked.
- R13: If `fll_en` falls in the same cycle as the sample that would complete an averaging cycle, the disable wins. No load occurs, and that cycle's partial result is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | One-cycle strobe: a new window error is present |
| smp_err | input | ERR_W (20) | Signed error count of the window |
| fll_en | input | 1 | Loop enable; low forces the off state |
| vote_mode | input | 1 | 0 = sum correction, 1 = sign-vote correction |
| slope_neg | input | 1 | 1 = positive error raises the code |
| inhibit_en | input | 1 | Allows gating of reference outputs while unlocked |
| cfg_err_lim | input | ERR_W (20) | Largest accepted error magnitude |
| cfg_avg_n | input | CNT_W (8) | Accepted samples per averaging cycle (0 acts as 1) |
| cfg_lock_n | input | CNT_W (8) | Clean cycles needed to lock (0 acts as 1) |
| cfg_hold_max | input | CNT_W (8) | Extra rejections tolerated in holdover |
| dac_code | output | DAC_W (14) | Tuning code for the control-voltage converter |
| dac_load | output | 1 | One-cycle pulse when a new code is issued |
| fll_state | output | 2 | 0 unlocked, 1 locked, 2 holdover, 3 off |
| led_red | output | 1 | Red lamp drive |
| led_green | output | 1 | Green lamp drive |
| ref_inhibit | output | 1 | Gate for the reference outputs |

## Verification
The cycle-ending sample and a fall of `fll_en` can land in the same clock. In that case the accumulator would issue a load while the lock-state machine moves to off. The bench drops the enable on the very edge that carries the fourth accepted sample. It judges the result by the absence of any `dac_load` and an unchanged code. It then re-enables and shows that a full set of new samples is needed before the next load. A second coincidence is the cycle end that also completes the lock count. There the bench expects the load and the locked state to appear together.

// File: rtl/fll_pkg.sv
package fll_pkg;

    typedef enum logic [1:0] {
        ST_UNLOCK = 2'd0,
        ST_LOCK   = 2'd1,
        ST_HOLD   = 2'd2,
        ST_OFF    = 2'd3
    } fll_state_e;

    // Classification of one sample strobe
    typedef struct packed {
        logic accept;
        logic reject;
        logic discard;
    } smp_class_t;

    // Lamp drive: {red, green}
    typedef struct packed {
        logic red;
        logic green;
    } lamp_t;

    function automatic lamp_t lamp_of(fll_state_e s);
        lamp_t l;
        case (s)
            ST_LOCK: l = '{red: 1'b0, green: 1'b1};
            ST_HOLD: l = '{red: 1'b1, green: 1'b1};
            default: l = '{red: 1'b1, green: 1'b0};
        endcase
        return l;
    endfunction

endpackage

// File: rtl/fll_sample_qual.sv
module fll_sample_qual
    import fll_pkg::*;
#(
    parameter int ERR_W = 20
) (
    input  logic             smp_vld,
    input  logic             run,
    input  logic             settle,
    input  logic [ERR_W-1:0] smp_err,
    input  logic [ERR_W-1:0] cfg_err_lim,
    output smp_class_t       cls
);
    logic [ERR_W:0] err_x;
    logic [ERR_W:0] mag;
    logic           in_lim;
    logic           live;

    always_comb begin
        err_x  = {smp_err[ERR_W-1], smp_err};
        mag    = smp_err[ERR_W-1] ? (~err_x + 1'b1) : err_x;
        in_lim = (mag <= {1'b0, cfg_err_lim});
        live   = smp_vld && run;
        cls.discard = live && settle;
        cls.accept  = live && !settle && in_lim;
        cls.reject  = live && !settle && !in_lim;
    end
endmodule

// File: rtl/fll_accum.sv
module fll_accum
    import fll_pkg::*;
#(
    parameter int ERR_W  = 20,
    parameter int CNT_W  = 8,
    parameter int ACC_W  = ERR_W + CNT_W,
    parameter int VOTE_W = CNT_W + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run,
    input  smp_class_t               cls,
    input  logic [ERR_W-1:0]         smp_err,
    input  logic [CNT_W-1:0]         cfg_avg_n,
    output logic                     settle,
    output logic                     cycle_end,
    output logic                     cycle_clean,
    output logic signed [ACC_W-1:0]  sum_total,
    output logic signed [VOTE_W-1:0] vote_total
);
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [VOTE_W-1:0] vote_q;
    logic signed [VOTE_W-1:0] vote_inc;
    logic [CNT_W-1:0]         cnt_q;
    logic [CNT_W-1:0]         cnt_inc;
    logic [CNT_W-1:0]         avg_tgt;
    logic                     clean_q;
    logic                     settle_q;
    logic                     err_zero;

    always_comb begin
        err_zero  = (smp_err == '0);
        sum_total = acc_q + $signed({{CNT_W{smp_err[ERR_W-1]}}, smp_err});
        if (err_zero)
            vote_inc = '0;
        else if (smp_err[ERR_W-1])
            vote_inc = '1;
        else
            vote_inc = VOTE_W'(1);
        vote_total  = vote_q + vote_inc;
        cnt_inc     = cnt_q + 1'b1;
        avg_tgt     = (cfg_avg_n == '0) ? CNT_W'(1) : cfg_avg_n;
        cycle_end   = cls.accept && (cnt_inc >= avg_tgt);
        cycle_clean = clean_q;
        settle      = settle_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc_q    <= '0;
            vote_q   <= '0;
            cnt_q    <= '0;
            clean_q  <= 1'b1;
            settle_q <= 1'b0;
        end else if (cls.discard) begin
            settle_q <= 1'b0;
        end else if (cls.reject) begin
            clean_q <= 1'b0;
        end else if (cls.accept) begin
            if (cycle_end) begin
                acc_q    <= '0;
                vote_q   <= '0;
                cnt_q    <= '0;
                clean_q  <= 1'b1;
                settle_q <= 1'b1;
            end else begin
                acc_q  <= sum_total;
                vote_q <= vote_total;
                cnt_q  <= cnt_inc;
            end
        end
    end
endmodule

// File: rtl/fll_dac_step.sv
module fll_dac_step #(
    parameter int DAC_W     = 14,
    parameter int ACC_W     = 28,
    parameter int VOTE_W    = 10,
    parameter int SUM_SHIFT = 2
) (
    input  logic [DAC_W-1:0]         cur_code,
    input  logic signed [ACC_W-1:0]  sum_total,
    input  logic signed [VOTE_W-1:0] vote_total,
    input  logic                     vote_mode,
    input  logic                     slope_neg,
    output logic [DAC_W-1:0]         nxt_code
);
    localparam int WW = ((ACC_W > DAC_W) ? ACC_W : DAC_W) + 2;

    logic signed [WW-1:0] cur_w;
    logic signed [WW-1:0] max_w;
    logic signed [WW-1:0] delta_w;
    logic signed [WW-1:0] step_w;
    logic signed [WW-1:0] corr_w;
    logic signed [WW-1:0] cand_w;

    always_comb begin
        cur_w   = $signed({{(WW-DAC_W){1'b0}}, cur_code});
        max_w   = $signed({{(WW-DAC_W){1'b0}}, {DAC_W{1'b1}}});
        delta_w = $signed({{(WW-ACC_W){sum_total[ACC_W-1]}}, sum_total}) >>> SUM_SHIFT;
        if (vote_total > 0)
            step_w = WW'(1);
        else if (vote_total < 0)
            step_w = '1;
        else
            step_w = '0;
        corr_w = vote_mode ? step_w : delta_w;
        cand_w = slope_neg ? (cur_w + corr_w) : (cur_w - corr_w);
        if (cand_w < 0)
            nxt_code = '0;
        else if (cand_w > max_w)
            nxt_code = {DAC_W{1'b1}};
        else
            nxt_code = cand_w[DAC_W-1:0];
    end
endmodule

// File: rtl/fll_lock_fsm.sv
module fll_lock_fsm
    import fll_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fll_en,
    input  smp_class_t       cls,
    input  logic             cycle_end,
    input  logic             cycle_clean,
    input  logic [CNT_W-1:0] cfg_lock_n,
    input  logic [CNT_W-1:0] cfg_hold_max,
    output fll_state_e       state
);
    fll_state_e       st_q, st_d;
    logic [CNT_W-1:0] good_q, good_d;
    logic [CNT_W-1:0] hold_q, hold_d;
    logic [CNT_W-1:0] lock_tgt;
    logic [CNT_W-1:0] good_inc;

    always_comb begin
        st_d     = st_q;
        good_d   = good_q;
        hold_d   = hold_q;
        lock_tgt = (cfg_lock_n == '0) ? CNT_W'(1) : cfg_lock_n;
        good_inc = good_q + 1'b1;
        if (!fll_en) begin
            st_d   = ST_OFF;
            good_d = '0;
            hold_d = '0;
        end else begin
            case (st_q)
                ST_OFF: begin
                    st_d   = ST_UNLOCK;
                    good_d = '0;
                end
                ST_UNLOCK: begin
                    if (cls.reject) begin
                        good_d = '0;
                    end else if (cycle_end && cycle_clean) begin
                        if (good_inc >= lock_tgt) begin
                            st_d   = ST_LOCK;
                            good_d = '0;
                        end else begin
                            good_d = good_inc;
                        end
                    end
                end
                ST_LOCK: begin
                    if (cls.reject) begin
                        st_d   = ST_HOLD;
                        hold_d = '0;
                    end
                end
                ST_HOLD: begin
                    if (cls.accept) begin
                        st_d = ST_LOCK;
                    end else if (cls.reject) begin
                        if (hold_q >= cfg_hold_max) begin
                            st_d   = ST_UNLOCK;
                            good_d = '0;
                        end else begin
                            hold_d = hold_q + 1'b1;
                        end
                    end
                end
                default: st_d = ST_UNLOCK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_UNLOCK;
            good_q <= '0;
            hold_q <= '0;
        end else begin
            st_q   <= st_d;
            good_q <= good_d;
            hold_q <= hold_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/fll_ctrl.sv
module fll_ctrl
    import fll_pkg::*;
#(
    parameter int ERR_W     = 20,
    parameter int CNT_W     = 8,
    parameter int DAC_W     = 14,
    parameter int SUM_SHIFT = 2,
    parameter int DAC_INIT  = 8192
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [ERR_W-1:0] smp_err,
    input  logic             fll_en,
    input  logic             vote_mode,
    input  logic             slope_neg,
    input  logic             inhibit_en,
    input  logic [ERR_W-1:0] cfg_err_lim,
    input  logic [CNT_W-1:0] cfg_avg_n,
    input  logic [CNT_W-1:0] cfg_lock_n,
    input  logic [CNT_W-1:0] cfg_hold_max,
    output logic [DAC_W-1:0] dac_code,
    output logic             dac_load,
    output logic [1:0]       fll_state,
    output logic             led_red,
    output logic             led_green,
    output logic             ref_inhibit
);
    localparam int ACC_W  = ERR_W + CNT_W;
    localparam int VOTE_W = CNT_W + 2;

    fll_state_e               state;
    smp_class_t               cls;
    logic                     run;
    logic                     settle;
    logic                     cycle_end;
    logic                     cycle_clean;
    logic signed [ACC_W-1:0]  sum_total;
    logic signed [VOTE_W-1:0] vote_total;
    logic [DAC_W-1:0]         code_q;
    logic [DAC_W-1:0]         code_nxt;
    logic                     load_q;
    lamp_t                    lamp;

    assign run = fll_en && (state != ST_OFF);

    fll_sample_qual #(.ERR_W(ERR_W)) qual_i (
        .smp_vld     (smp_vld),
        .run         (run),
        .settle      (settle),
        .smp_err     (smp_err),
        .cfg_err_lim (cfg_err_lim),
        .cls         (cls)
    );

    fll_accum #(.ERR_W(ERR_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .VOTE_W(VOTE_W)) accum_i (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .cls         (cls),
        .smp_err     (smp_err),
        .cfg_avg_n   (cfg_avg_n),
        .settle      (settle),
        .cycle_end   (cycle_end),
        .cycle_clean (cycle_clean),
        .sum_total   (sum_total),
        .vote_total  (vote_total)
    );

    fll_dac_step #(.DAC_W(DAC_W), .ACC_W(ACC_W), .VOTE_W(VOTE_W), .SUM_SHIFT(SUM_SHIFT)) step_i (
        .cur_code   (code_q),
        .sum_total  (sum_total),
        .vote_total (vote_total),
        .vote_mode  (vote_mode),
        .slope_neg  (slope_neg),
        .nxt_code   (code_nxt)
    );

    fll_lock_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk          (clk),
        .rst          (rst),
        .fll_en       (fll_en),
        .cls          (cls),
        .cycle_end    (cycle_end),
        .cycle_clean  (cycle_clean),
        .cfg_lock_n   (cfg_lock_n),
        .cfg_hold_max (cfg_hold_max),
        .state        (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= DAC_W'(DAC_INIT);
            load_q <= 1'b0;
        end else begin
            load_q <= cycle_end;
            if (cycle_end)
                code_q <= code_nxt;
        end
    end

    always_comb begin
        lamp        = lamp_of(state);
        dac_code    = code_q;
        dac_load    = load_q;
        fll_state   = state;
        led_red     = lamp.red;
        led_green   = lamp.green;
        ref_inhibit = inhibit_en && (state == ST_UNLOCK);
    end
endmodule

// File: rtl/fll_ctrl_chk.sv
module fll_ctrl_chk
    import fll_pkg::*;
#(
    parameter int DAC_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             fll_en,
    input logic             vote_mode,
    input logic [DAC_W-1:0] dac_code,
    input logic             dac_load,
    input logic [1:0]       fll_state
);
    // R5: a settling discard separates two loads
    a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        dac_load |=> !dac_load);

    // R3: the code moves only together with a load pulse
    a_r3_code_moves_on_load: assert property (@(posedge clk) disable iff (rst)
        !dac_load |-> $stable(dac_code));

    // R6: vote mode changes the code by at most one
    a_r6_vote_unit_step: assert property (@(posedge clk) disable iff (rst)
        (dac_load && $past(vote_mode)) |->
            ((dac_code == $past(dac_code)) ||
             (dac_code == $past(dac_code) + 1'b1) ||
             (dac_code == $past(dac_code) - 1'b1)));

    // R10: no load while off, and a low enable forces off
    a_r10_off_no_load: assert property (@(posedge clk) disable iff (rst)
        (fll_state == ST_OFF) |-> !dac_load);

    a_r10_off_follows_enable: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(fll_en)) |-> (fll_state == ST_OFF));

    // R9: holdover is only entered from locked
    a_r9_hold_from_lock: assert property (@(posedge clk) disable iff (rst)
        ((fll_state == ST_HOLD) && ($past(fll_state) != ST_HOLD)) |->
            ($past(fll_state) == ST_LOCK));

    // R8: locked is reached from unlocked or holdover only
    a_r8_lock_entry: assert property (@(posedge clk) disable iff (rst)
        ((fll_state == ST_LOCK) && ($past(fll_state) != ST_LOCK)) |->
            (($past(fll_state) == ST_UNLOCK) || ($past(fll_state) == ST_HOLD)));
endmodule

bind fll_ctrl fll_ctrl_chk #(.DAC_W(DAC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .fll_en    (fll_en),
    .vote_mode (vote_mode),
    .dac_code  (dac_code),
    .dac_load  (dac_load),
    .fll_state (fll_state)
);

// File: tb/fll_ctrl_tb_top.sv
module fll_ctrl_tb_top;
    localparam int ERR_W = 20;
    localparam int CNT_W = 8;
    localparam int DAC_W = 14;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_vld = 1'b0;
    logic [ERR_W-1:0] smp_err = '0;
    logic             fll_en = 1'b1;
    logic             vote_mode = 1'b0;
    logic             slope_neg = 1'b0;
    logic             inhibit_en = 1'b1;
    logic [ERR_W-1:0] cfg_err_lim = ERR_W'(100);
    logic [CNT_W-1:0] cfg_avg_n = CNT_W'(4);
    logic [CNT_W-1:0] cfg_lock_n = CNT_W'(2);
    logic [CNT_W-1:0] cfg_hold_max = CNT_W'(2);
    logic [DAC_W-1:0] dac_code;
    logic             dac_load;
    logic [1:0]       fll_state;
    logic             led_red;
    logic             led_green;
    logic             ref_inhibit;

    int n_chk = 0;
    int n_err = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #2 clk = ~clk;

    fll_ctrl dut_i (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_err(smp_err),
        .fll_en(fll_en), .vote_mode(vote_mode), .slope_neg(slope_neg),
        .inhibit_en(inhibit_en), .cfg_err_lim(cfg_err_lim),
        .cfg_avg_n(cfg_avg_n), .cfg_lock_n(cfg_lock_n),
        .cfg_hold_max(cfg_hold_max), .dac_code(dac_code),
        .dac_load(dac_load), .fll_state(fll_state), .led_red(led_red),
        .led_green(led_green), .ref_inhibit(ref_inhibit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input int e);
        @(negedge clk);
        smp_vld = 1'b1;
        smp_err = ERR_W'(e);
        @(negedge clk);
        smp_vld = 1'b0;
        smp_err = '0;
    endtask

    task automatic expect_load(input int code);
        exp_q.push_back(code);
    endtask

    task automatic chk_state(input int s, input string req);
        check(fll_state == 2'(s), req, fll_state, s);
    endtask

    // Monitor: every load must match the next queued code (R3)
    always @(negedge clk) begin
        if (!rst && dac_load) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected load", dac_code, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(dac_code == DAC_W'(e), "R3 load code", dac_code, e);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_state(0, "R1 state");
        check(dac_code == 14'd8192, "R1 code", dac_code, 8192);
        check(dac_load == 1'b0, "R1 load", dac_load, 0);
        check(led_red && !led_green, "R1 lamps", {led_red, led_green}, 2);
        check(ref_inhibit == 1'b1, "R1 R12 inhibit", ref_inhibit, 1);

        // R2 R4: sum cycle with one rejected sample
        send(10); send(20); send(500); send(-5);
        check(dac_code == 14'd8192, "R2 no early load", dac_code, 8192);
        expect_load(8182);
        send(15);
        // R5: settle sample discarded (would shorten next cycle if counted)
        send(40);
        send(8); send(8); send(8);
        expect_load(8174);
        send(8);
        chk_state(0, "R8 one clean cycle unlocked");
        send(0);
        send(-8); send(-8); send(-8);
        expect_load(8182);
        send(-8);
        chk_state(1, "R8 locked with load");
        check(!led_red && led_green, "R11 green", {led_red, led_green}, 1);
        check(ref_inhibit == 1'b0, "R12 no inhibit locked", ref_inhibit, 0);

        // R9 holdover
        send(0);
        send(500);
        chk_state(2, "R9 hold entry");
        check(led_red && led_green, "R11 amber", {led_red, led_green}, 3);
        send(3);
        chk_state(1, "R9 back to lock");
        send(500); send(500); send(500);
        chk_state(2, "R9 still hold");
        send(500);
        chk_state(0, "R9 unlocked");
        check(ref_inhibit == 1'b1, "R12 inhibit unlocked", ref_inhibit, 1);

        // R10 disable
        fll_en = 1'b0;
        repeat (2) @(negedge clk);
        chk_state(3, "R10 off");
        check(led_red && !led_green, "R11 red off", {led_red, led_green}, 2);
        check(ref_inhibit == 1'b0, "R12 no inhibit off", ref_inhibit, 0);
        send(50); send(50); send(50); send(50);
        check(dac_code == 14'd8182, "R10 code held", dac_code, 8182);
        fll_en = 1'b1;
        repeat (2) @(negedge clk);
        chk_state(0, "R10 re-enable unlocked");

        // R6 voting
        vote_mode = 1'b1;
        send(90); send(-1); send(2);
        expect_load(8182);
        send(-100);
        send(0);
        send(1); send(1); send(1);
        expect_load(8181);
        send(-90);
        chk_state(1, "R8 locked after vote cycles");
        send(0);
        slope_neg = 1'b1;
        send(-1); send(-1); send(-1);
        expect_load(8180);
        send(-1);

        // R7 clamps in sum mode
        vote_mode = 1'b0;
        slope_neg = 1'b0;
        cfg_err_lim = ERR_W'(500000);
        send(0);
        send(400000); send(400000); send(400000);
        expect_load(0);
        send(400000);
        check(dac_code == 14'd0, "R7 low clamp", dac_code, 0);
        send(0);
        send(-400000); send(-400000); send(-400000);
        expect_load(16383);
        send(-400000);
        check(dac_code == 14'd16383, "R7 high clamp", dac_code, 16383);

        // R13 disable on the cycle-ending sample
        send(0);
        send(5); send(5); send(5);
        @(negedge clk);
        smp_vld = 1'b1;
        smp_err = ERR_W'(5);
        fll_en = 1'b0;
        @(negedge clk);
        smp_vld = 1'b0;
        smp_err = '0;
        repeat (2) @(negedge clk);
        chk_state(3, "R13 off wins");
        check(dac_code == 14'd16383, "R13 code kept", dac_code, 16383);
        fll_en = 1'b1;
        repeat (2) @(negedge clk);
        send(0); send(0); send(0);
        expect_load(16383);
        send(0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 all loads seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule